// File: doc/BRIEF.md
# Stochastic Probability Divider

This block takes two unipolar random bit streams and produces a third stream whose ON probability approximates the ratio of the numerator probability to the denominator probability. Each input bit is treated as one sample of a Bernoulli sequence. A downstream counter or filter recovers the quotient by averaging the output stream over many clocks. No arithmetic divider is used. The quotient comes from a feedback loop that settles where the chance of moving up equals the chance of moving down.

There are two modes. The toggle mode uses a single state bit, and its result is p1/(p1+p2). That value is close to p1/p2 only when p1 is much smaller than p2. The count mode holds an up/down counter. The numerator stream counts it up. The denominator stream, gated by the block's own output, counts it down. The output is ON whenever the count is above a pseudo-random word of the same width. The loop balances when p2·p0 = p1. The count is exposed as a port so that a parallel estimate of the quotient is also available.

Top module: `stoch_divider`

## Requirements
- R1: While rst_n is low, q_out is 0 and count_o is 0.
- R2: With mode_sel = 0, on each clock the state bit that drives q_out becomes 1 for (x_num=1, x_den=0), becomes 0 for (0,1), inverts for (1,1) and keeps its value for (0,0).
- R3: With mode_sel = 0 and independent random inputs, the long-run fraction of ON output bits is p1/(p1+p2). The counter stays at 0 in this mode.
- R4: With mode_sel = 1, x_num = 1 and no decrement requested, count_o rises by exactly 1 per clock.
- R5: With mode_sel = 1, a decrement is requested only when x_den and q_out are both 1. The count never goes below 0.
- R6: With mode_sel = 1, when an increment and a decrement are requested in the same clock, count_o holds. When both inputs are 1, count_o therefore never decreases.
- R7: count_o saturates at its all-ones value and never wraps to 0.
- R8: With mode_sel = 1, q_out is 1 exactly when count_o is greater than the low CW bits of an internal 16-bit LFSR word. A count of 0 therefore always gives q_out = 0.
- R9: With mode_sel = 1 and p1 < p2, the long-run output ON fraction approaches p1/p2.
- R10: With mode_sel = 1 and p1 ≥ p2, the output saturates to nearly all ON.
- R11: On the first clock after mode_sel changes value, both the state bit and the counter are cleared to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 1 | 0 selects the toggle divider, 1 selects the count divider |
| x_num | input | 1 | Numerator stream bit, probability p1 |
| x_den | input | 1 | Denominator stream bit, probability p2 |
| q_out | output | 1 | Quotient stream bit |
| count_o | output | CW | Current counter value |

## Verification
The toggle mode is first driven with a fixed sequence that covers all four input combinations, including two toggles in a row. This separates the set, clear, invert and hold rules from one another. It is then driven with random streams at 1/4 and 3/4, where the expected ratio is 1/4 and not p1/p2. The count mode is tried with pure numerator input, pure denominator input at a zero count, and both inputs held high. These patterns expose errors in the increment path, the decrement gating and the hold case, and they also exercise the saturation limit. Random streams with p1 < p2 and p1 > p2 tell a correct p1/p2 equilibrium apart from the saturated regime. A mode switch with a nonzero count checks the clearing rule.

// File: rtl/stoch_divider.sv
module stoch_divider #(
  parameter int          CW   = 8,
  parameter logic [15:0] SEED = 16'hACE1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_sel,
  input  logic          x_num,
  input  logic          x_den,
  output logic          q_out,
  output logic [CW-1:0] count_o
);
  localparam logic [CW-1:0] CMAX = {CW{1'b1}};
  localparam logic [15:0]   TAPS = 16'hB400;

  logic          ff_q, mode_q;
  logic [CW-1:0] cnt;
  logic [15:0]   lfsr;

  wire cmp_on   = cnt > lfsr[CW-1:0];
  wire mode_chg = mode_sel != mode_q;
  wire inc_req  = x_num;
  wire dec_req  = x_den & q_out;

  assign q_out   = mode_sel ? cmp_on : ff_q;
  assign count_o = cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ff_q   <= 1'b0;
      mode_q <= 1'b0;
      cnt    <= '0;
      lfsr   <= SEED;
    end else begin
      lfsr   <= {1'b0, lfsr[15:1]} ^ (lfsr[0] ? TAPS : 16'h0);
      mode_q <= mode_sel;
      if (mode_chg) begin
        ff_q <= 1'b0;
        cnt  <= '0;
      end else if (!mode_sel) begin
        case ({x_num, x_den})
          2'b10:   ff_q <= 1'b1;
          2'b01:   ff_q <= 1'b0;
          2'b11:   ff_q <= ~ff_q;
          default: ff_q <= ff_q;
        endcase
      end else begin
        if (inc_req && !dec_req && cnt != CMAX)
          cnt <= cnt + 1'b1;
        else if (dec_req && !inc_req && cnt != '0)
          cnt <= cnt - 1'b1;
      end
    end
  end
endmodule

// File: rtl/stoch_divider_chk.sv
module stoch_divider_chk #(
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mode_sel,
  input logic          mode_q,
  input logic          x_num,
  input logic          x_den,
  input logic          q_out,
  input logic [CW-1:0] count_o
);
  localparam logic [CW-1:0] CMAX = {CW{1'b1}};

  AST_FF_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_sel && !mode_q && x_num && !x_den) |=> (mode_sel || q_out)); // R2
  AST_FF_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_sel && !mode_q && !x_num && x_den) |=> (mode_sel || !q_out)); // R2
  AST_CNT_INC: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel && mode_q && x_num && !(x_den && q_out) && count_o != CMAX)
      |=> count_o == $past(count_o) + 1'b1); // R4
  AST_BOTH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel && mode_q && x_num && x_den) |=> count_o >= $past(count_o)); // R6
  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel && mode_q && x_num && count_o == CMAX) |=> count_o == CMAX); // R7
  AST_ZERO_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel && count_o == '0) |-> !q_out); // R8
  AST_MODE_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel != mode_q) |=> count_o == '0); // R11
endmodule

bind stoch_divider stoch_divider_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .mode_q(mode_q),
  .x_num(x_num), .x_den(x_den), .q_out(q_out), .count_o(count_o)
);

// File: tb/tb_stoch_divider.sv
module tb_stoch_divider;
  localparam int CW = 8;
  localparam int CMAXI = (1 << CW) - 1;

  logic clk = 1'b0, rst_n = 1'b0, mode_sel = 1'b0, x_num = 1'b0, x_den = 1'b0;
  logic q_out;
  logic [CW-1:0] count_o;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  stoch_divider #(.CW(CW)) dut (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .x_num(x_num),
    .x_den(x_den), .q_out(q_out), .count_o(count_o)
  );

  // {x_num, x_den, expected q_out after the clock}
  localparam logic [2:0] VEC [8] = '{
    3'b101, 3'b001, 3'b110, 3'b111, 3'b010, 3'b000, 3'b111, 3'b010
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input logic n, input logic d);
    x_num = n; x_den = d;
    @(negedge clk);
  endtask

  function automatic logic rbit(input int p256);
    return ($urandom % 256) < p256;
  endfunction

  initial begin
    #(200000 * 10);
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int ones, prev;
    bit mono;
    void'($urandom(7));
    repeat (3) @(negedge clk);
    chk(q_out == 1'b0, "R1 q_out", q_out, 0);
    chk(count_o == 0, "R1 count", count_o, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 8; i++) begin
      step(VEC[i][2], VEC[i][1]);
      chk(q_out == VEC[i][0], $sformatf("R2 vec%0d", i), q_out, VEC[i][0]);
    end

    ones = 0;
    for (int i = 0; i < 4000; i++) begin
      step(rbit(64), rbit(192));
      ones += q_out;
    end
    chk(ones > 720 && ones < 1280, "R3 ratio p1/(p1+p2)", ones, 1000);
    chk(count_o == 0, "R3 count idle", count_o, 0);

    mode_sel = 1'b1;
    step(0, 0);
    chk(count_o == 0, "R11 enter count mode", count_o, 0);

    mono = 1'b1;
    for (int i = 0; i < 10; i++) begin
      step(0, 1);
      if (count_o != 0 || q_out != 0) mono = 1'b0;
    end
    chk(mono, "R5 no underflow", count_o, 0);
    chk(q_out == 0, "R8 zero count gives low", q_out, 0);

    for (int i = 0; i < 5; i++) step(1, 0);
    chk(count_o == 5, "R4 increment", count_o, 5);

    mono = 1'b1;
    for (int i = 0; i < 100; i++) begin
      prev = count_o;
      step(1, 1);
      if (count_o < prev) mono = 1'b0;
    end
    chk(mono, "R6 both requested never decrements", count_o, 0);

    for (int i = 0; i < 300; i++) step(1, 0);
    chk(count_o == CMAXI, "R7 saturate", count_o, CMAXI);
    for (int i = 0; i < 10; i++) step(1, 1);
    chk(count_o == CMAXI, "R7 no wrap at full", count_o, CMAXI);

    for (int i = 0; i < 1000; i++) step(rbit(64), rbit(192));
    ones = 0;
    for (int i = 0; i < 6000; i++) begin
      step(rbit(64), rbit(192));
      ones += q_out;
    end
    chk(ones > 1400 && ones < 2600, "R9 ratio p1/p2", ones, 2000);

    for (int i = 0; i < 1000; i++) step(rbit(192), rbit(128));
    ones = 0;
    for (int i = 0; i < 2000; i++) begin
      step(rbit(192), rbit(128));
      ones += q_out;
    end
    chk(ones > 1700, "R10 saturated output", ones, 2000);

    mono = 1'b1;
    for (int i = 0; i < 4000; i++) begin
      prev = count_o;
      step(0, 1);
      if (count_o > prev) mono = 1'b0;
    end
    chk(mono && count_o == 0, "R5 drains to zero", count_o, 0);

    for (int i = 0; i < 20; i++) step(1, 0);
    chk(count_o == 20, "R4 increment from zero", count_o, 20);
    mode_sel = 1'b0;
    step(0, 0);
    chk(count_o == 0, "R11 count cleared", count_o, 0);
    chk(q_out == 0, "R11 state cleared", q_out, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule